// File: doc/BRIEF.md
# Sample-and-Hold Refresh Sequencer

This block keeps sixteen analog hold channels topped up from a small code memory. It walks the channels in a ring: for each one it reads the stored code, presents it on a shared converter bus, and then fires a one-cycle sample strobe for that channel. Its pace is set by a sequencer tick. The tick comes either from a parameterized divider of the system clock or from an external clock that is sampled, edge-detected and divided by four.

A serial front end, outside this block, hands over complete words. Each word carries an address, a code, an immediate bit and a clock-source bit. While chip select is low the ring pauses. The slot in progress completes, and no new slot starts. When chip select rises, the ring continues at the channel where it stopped. If an immediate word was received, its channel is serviced first. A reset, either the system reset or a reset request input, starts a sweep that cannot be interrupted. The sweep writes a default code to every channel and strobes each one, always paced by the internal divider.

Top module: `refresh_sequencer`

## Requirements
- R1: At most one bit of `sample_strobe` is high in any cycle. When bit k pulses, `dac_code` holds the code stored for channel k. Outside interruptions, channels are strobed in ascending order 0..15 and wrap back to 0.
- R2: Each channel occupies two sequencer ticks: a load tick and a strobe tick. With the internal source a tick occurs every INT_DIV system clocks, so consecutive strobes are 2*INT_DIV clocks apart.
- R3: The external source is used when `ext_sel_pin` is 1 or when the last accepted word had `word_ext` = 1 (logical OR). In that case one tick occurs per four rising edges of `ext_clk`, and the internal divider is halted. With the external source selected and `ext_clk` stopped, no strobes occur.
- R4: When `cs_n` goes low, a slot that has already loaded its code still completes its strobe. No further slot starts while `cs_n` stays low.
- R5: After a frame with no immediate word, the first strobe after `cs_n` returns high is for the channel that follows the last channel strobed.
- R6: A word accepted with `word_imm` = 1 or `imm_pin` = 1 marks its channel for immediate service. After `cs_n` rises, that channel is strobed with its new code within 2*INT_DIV+3 clocks. The next strobe is for the channel that follows the last one strobed before the frame.
- R7: Each accepted word stores `word_code` at channel `word_addr` (0..15). The new value appears on `dac_code` when that channel's turn comes in the ring.
- R8: A reset (`rst` high, or a `reset_req` pulse) raises `busy`. It then writes code 0x4F2C to channels 0..15 in order and strobes each one with `dac_code` = 0x4F2C. `busy` falls in the same cycle as the strobe of channel 15.
- R9: During the sweep the internal divider paces the ticks whatever the clock selection is. `cs_n` and `word_valid` have no effect, and a word offered during the sweep is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; starts a sweep |
| reset_req | input | 1 | Active-high request for a default-code sweep |
| cs_n | input | 1 | Serial chip select, active low; pauses the ring |
| ext_clk | input | 1 | External sequencer clock, sampled by `clk` |
| ext_sel_pin | input | 1 | Forces the external tick source |
| imm_pin | input | 1 | Forces immediate service of accepted words |
| word_valid | input | 1 | One-cycle pulse: a complete word is available |
| word_addr | input | 4 | Channel address of the word |
| word_code | input | 16 | Code of the word |
| word_imm | input | 1 | Immediate-service bit of the word |
| word_ext | input | 1 | Clock-source bit of the word, kept until the next word |
| dac_code | output | 16 | Code presented to the shared converter |
| sample_strobe | output | 16 | One-hot sample strobe per channel |
| busy | output | 1 | High while the reset sweep runs |

## Verification
The assertions check properties that must hold on every cycle: the strobe vector is one-hot or zero, no new slot loads while chip select is low, every strobe during the sweep carries the default code, the sweep ends exactly on channel 15, and an external-source tick is always preceded by a sampled rising edge. The directed scenarios cover behaviour that spans many ticks. These include the resume point after a pause, the bound on immediate service, burst values reaching their channels on their turns, the strobe spacing for both tick sources, and the fact that words and chip select are ignored during the sweep. Each of these is shown by observing strobes and codes at the ports.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic {
    PH_LOAD   = 1'b0,
    PH_STROBE = 1'b1
  } phase_t;
endpackage

// File: rtl/seq_tick_gen.sv
module seq_tick_gen #(
  parameter int INT_DIV = 200,
  parameter int EXT_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_clk,
  input  logic use_ext,
  output logic tick
);
  localparam int CW = (INT_DIV > 2) ? $clog2(INT_DIV) : 1;
  localparam int EW = (EXT_DIV > 2) ? $clog2(EXT_DIV) : 1;

  logic [2:0]    ext_s;
  logic          ext_rise;
  logic [CW-1:0] int_cnt;
  logic [EW-1:0] ext_cnt;

  always_ff @(posedge clk) begin
    if (rst) ext_s <= '0;
    else     ext_s <= {ext_s[1:0], ext_clk};
  end

  assign ext_rise = ext_s[1] & ~ext_s[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      int_cnt <= '0;
      ext_cnt <= '0;
      tick    <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (use_ext) begin
        int_cnt <= '0;
        if (ext_rise) begin
          if (ext_cnt == EW'(EXT_DIV - 1)) begin
            ext_cnt <= '0;
            tick    <= 1'b1;
          end else begin
            ext_cnt <= ext_cnt + 1'b1;
          end
        end
      end else begin
        ext_cnt <= '0;
        if (int_cnt == CW'(INT_DIV - 1)) begin
          int_cnt <= '0;
          tick    <= 1'b1;
        end else begin
          int_cnt <= int_cnt + 1'b1;
        end
      end
    end
  end

  // R3: with the external source held, a tick needs a sampled rising edge
  p_ext_edge_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && $past(use_ext)) |-> $past(ext_rise));
endmodule

// File: rtl/seq_code_ram.sv
module seq_code_ram #(
  parameter int NCH = 16,
  parameter int DW  = 16,
  localparam int AW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [NCH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/seq_core.sv
module seq_core
  import seq_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DW  = 16,
  parameter logic [DW-1:0] DEF_CODE = 16'h4F2C,
  localparam int AW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sweep_req,
  input  logic          tick,
  input  logic          cs_n,
  input  logic          word_valid,
  input  logic [AW-1:0] word_addr,
  input  logic [DW-1:0] word_code,
  input  logic          word_imm_eff,
  input  logic          word_ext,
  input  logic [DW-1:0] ram_q,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [DW-1:0] ram_wdata,
  output logic [AW-1:0] ram_raddr,
  output logic          ext_bit,
  output logic [DW-1:0] dac_code,
  output logic [NCH-1:0] sample_strobe,
  output logic          busy
);
  phase_t        phase;
  logic [AW-1:0] ptr;
  logic [AW-1:0] cur;
  logic          svc;
  logic          pend_v;
  logic [AW-1:0] pend_addr;
  logic [AW-1:0] ptr_nxt;

  assign ptr_nxt   = (ptr == AW'(NCH - 1)) ? '0 : ptr + 1'b1;
  assign ram_we    = busy ? (tick && phase == PH_LOAD) : word_valid;
  assign ram_waddr = busy ? ptr : word_addr;
  assign ram_wdata = busy ? DEF_CODE : word_code;
  assign ram_raddr = pend_v ? pend_addr : ptr;

  always_ff @(posedge clk) begin
    if (rst || sweep_req) begin
      busy          <= 1'b1;
      phase         <= PH_LOAD;
      ptr           <= '0;
      cur           <= '0;
      svc           <= 1'b0;
      pend_v        <= 1'b0;
      pend_addr     <= '0;
      ext_bit       <= 1'b0;
      dac_code      <= '0;
      sample_strobe <= '0;
    end else begin
      sample_strobe <= '0;
      if (busy) begin
        if (tick) begin
          if (phase == PH_LOAD) begin
            dac_code <= DEF_CODE;
            cur      <= ptr;
            phase    <= PH_STROBE;
          end else begin
            sample_strobe[cur] <= 1'b1;
            phase              <= PH_LOAD;
            ptr                <= ptr_nxt;
            if (ptr == AW'(NCH - 1)) busy <= 1'b0;
          end
        end
      end else begin
        if (tick) begin
          if (phase == PH_STROBE) begin
            sample_strobe[cur] <= 1'b1;
            phase              <= PH_LOAD;
            if (svc) svc <= 1'b0;
            else     ptr <= ptr_nxt;
          end else if (cs_n) begin
            dac_code <= ram_q;
            phase    <= PH_STROBE;
            if (pend_v) begin
              cur    <= pend_addr;
              svc    <= 1'b1;
              pend_v <= 1'b0;
            end else begin
              cur <= ptr;
            end
          end
        end
        if (word_valid) begin
          ext_bit <= word_ext;
          if (word_imm_eff) begin
            pend_v    <= 1'b1;
            pend_addr <= word_addr;
          end
        end
      end
    end
  end

  // R1: never more than one channel sampled at once
  p_strobe_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sample_strobe));

  // R4: a pending load does not happen while chip select is low
  p_hold_on_cs_r4: assert property (@(posedge clk) disable iff (rst || sweep_req)
    (!busy && !cs_n && tick && phase == PH_LOAD) |=> ($stable(dac_code) && sample_strobe == '0));

  // R8: sweep strobes always carry the default code
  p_sweep_code_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && |sample_strobe) |-> dac_code == DEF_CODE);

  // R8: the sweep ends on the last channel's strobe
  p_sweep_end_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> sample_strobe[NCH-1]);
endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer #(
  parameter int NCH     = 16,
  parameter int DW      = 16,
  parameter int INT_DIV = 200,
  parameter int EXT_DIV = 4,
  parameter logic [DW-1:0] DEF_CODE = 16'h4F2C,
  localparam int AW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reset_req,
  input  logic           cs_n,
  input  logic           ext_clk,
  input  logic           ext_sel_pin,
  input  logic           imm_pin,
  input  logic           word_valid,
  input  logic [AW-1:0]  word_addr,
  input  logic [DW-1:0]  word_code,
  input  logic           word_imm,
  input  logic           word_ext,
  output logic [DW-1:0]  dac_code,
  output logic [NCH-1:0] sample_strobe,
  output logic           busy
);
  logic          tick;
  logic          use_ext;
  logic          ext_bit;
  logic          ram_we;
  logic [AW-1:0] ram_waddr;
  logic [AW-1:0] ram_raddr;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_q;

  assign use_ext = !busy && (ext_sel_pin || ext_bit);

  seq_tick_gen #(.INT_DIV(INT_DIV), .EXT_DIV(EXT_DIV)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .ext_clk (ext_clk),
    .use_ext (use_ext),
    .tick    (tick)
  );

  seq_code_ram #(.NCH(NCH), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_q)
  );

  seq_core #(.NCH(NCH), .DW(DW), .DEF_CODE(DEF_CODE)) u_core (
    .clk           (clk),
    .rst           (rst),
    .sweep_req     (reset_req),
    .tick          (tick),
    .cs_n          (cs_n),
    .word_valid    (word_valid),
    .word_addr     (word_addr),
    .word_code     (word_code),
    .word_imm_eff  (word_imm || imm_pin),
    .word_ext      (word_ext),
    .ram_q         (ram_q),
    .ram_we        (ram_we),
    .ram_waddr     (ram_waddr),
    .ram_wdata     (ram_wdata),
    .ram_raddr     (ram_raddr),
    .ext_bit       (ext_bit),
    .dac_code      (dac_code),
    .sample_strobe (sample_strobe),
    .busy          (busy)
  );
endmodule

// File: tb/refresh_sequencer_tb.sv
module refresh_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam int DW  = 16;
  localparam int DIV = 8;
  localparam logic [15:0] DEF = 16'h4F2C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reset_req = 1'b0;
  logic cs_n = 1'b1;
  logic ext_clk = 1'b0;
  logic ext_sel_pin = 1'b0;
  logic imm_pin = 1'b0;
  logic word_valid = 1'b0;
  logic [3:0] word_addr = '0;
  logic [15:0] word_code = '0;
  logic word_imm = 1'b0;
  logic word_ext = 1'b0;
  logic [15:0] dac_code;
  logic [15:0] sample_strobe;
  logic busy;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int s_cnt = 0;
  int s_ch = 0;
  int s_cyc = 0;
  logic [15:0] s_code = '0;
  int seen = 0;
  logic ext_run = 1'b0;
  logic [15:0] model [NCH];

  refresh_sequencer #(.NCH(NCH), .DW(DW), .INT_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .reset_req(reset_req), .cs_n(cs_n),
    .ext_clk(ext_clk), .ext_sel_pin(ext_sel_pin), .imm_pin(imm_pin),
    .word_valid(word_valid), .word_addr(word_addr), .word_code(word_code),
    .word_imm(word_imm), .word_ext(word_ext),
    .dac_code(dac_code), .sample_strobe(sample_strobe), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    repeat (3) @(negedge clk);
    if (ext_run) ext_clk = ~ext_clk;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst && (|sample_strobe)) begin
      for (int i = 0; i < NCH; i++) if (sample_strobe[i]) s_ch <= i;
      s_code <= dac_code;
      s_cyc  <= cyc;
      s_cnt  <= s_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic next_strobe(input string req);
    int n = 0;
    @(posedge clk);
    while (s_cnt == seen && n < 2000) begin
      @(posedge clk);
      n++;
    end
    check(s_cnt != seen, req, s_cnt, seen + 1);
    seen = s_cnt;
  endtask

  task automatic send_word(input int addr, input logic [15:0] code, input bit imm, input bit ext);
    @(negedge clk);
    word_valid = 1'b1; word_addr = 4'(addr); word_code = code;
    word_imm = imm; word_ext = ext;
    @(negedge clk);
    word_valid = 1'b0; word_imm = 1'b0; word_ext = 1'b0;
    @(negedge clk);
  endtask

  // R8 reset state and sweep; R2 spacing
  task automatic t_reset_sweep();
    int prev;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    seen = s_cnt;
    @(negedge clk);
    check(busy == 1'b1, "R8 busy after reset", busy, 1);
    check(sample_strobe == '0, "R8 no strobe after reset", sample_strobe, 0);
    for (int k = 0; k < NCH; k++) begin
      next_strobe("R8 sweep strobe");
      check(s_ch == k, "R8 sweep order", s_ch, k);
      check(s_code == DEF, "R8 sweep code", s_code, DEF);
      if (k > 0) check(s_cyc - prev == 2*DIV, "R2 strobe spacing", s_cyc - prev, 2*DIV);
      prev = s_cyc;
      model[k] = DEF;
    end
    @(negedge clk);
    check(busy == 1'b0, "R8 busy low after channel 15", busy, 0);
  endtask

  // R4, R5, R7, R1
  task automatic t_burst();
    int c0, c1, last;
    @(negedge clk);
    cs_n = 1'b0;
    c0 = s_cnt;
    repeat (3*DIV) @(negedge clk);
    c1 = s_cnt;
    last = s_ch;
    check(c1 - c0 <= 1, "R4 only slot in progress completes", c1 - c0, 1);
    for (int a = 0; a < NCH; a++) begin
      logic [15:0] v;
      v = 16'h1000 + 16'(a) * 16'h0111;
      send_word(a, v, 1'b0, 1'b0);
      model[a] = v;
    end
    repeat (4*DIV) @(negedge clk);
    check(s_cnt == c1, "R4 no strobe while cs low", s_cnt, c1);
    cs_n = 1'b1;
    seen = s_cnt;
    for (int k = 0; k < NCH; k++) begin
      int e;
      e = (last + 1 + k) % NCH;
      next_strobe("R5 resume strobe");
      check(s_ch == e, (k == 0) ? "R5 resume channel" : "R1 ring order", s_ch, e);
      check(s_code == model[e], "R7 burst value on turn", s_code, model[e]);
    end
  endtask

  // R6 immediate via word bit or pin
  task automatic t_immediate(input int addr, input logic [15:0] v, input bit by_pin);
    int last, rel, e;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (3*DIV) @(negedge clk);
    last = s_ch;
    imm_pin = by_pin;
    send_word(addr, v, !by_pin, 1'b0);
    imm_pin = 1'b0;
    model[addr] = v;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    rel = cyc;
    seen = s_cnt;
    next_strobe("R6 immediate strobe");
    check(s_ch == addr, "R6 immediate channel", s_ch, addr);
    check(s_code == v, "R6 immediate code", s_code, v);
    check(s_cyc - rel <= 2*DIV + 3, "R6 within two ticks", s_cyc - rel, 2*DIV + 3);
    e = (last + 1) % NCH;
    next_strobe("R6 resume strobe");
    check(s_ch == e, "R6 resume at interrupted channel", s_ch, e);
    check(s_code == model[e], "R1 code of resumed channel", s_code, model[e]);
  endtask

  // R3 external clock source
  task automatic t_external();
    int p, c;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (3*DIV) @(negedge clk);
    send_word(2, model[2], 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    ext_run = 1'b1;
    seen = s_cnt;
    next_strobe("R3 ext strobe a");
    next_strobe("R3 ext strobe b");
    p = s_cyc;
    next_strobe("R3 ext strobe c");
    check(s_cyc - p == 8*6, "R3 ext strobe spacing", s_cyc - p, 48);
    ext_run = 1'b0;
    repeat (60) @(negedge clk);
    c = s_cnt;
    repeat (300) @(negedge clk);
    check(s_cnt == c, "R3 stopped ext clock halts ring", s_cnt, c);
  endtask

  // R9 sweep ignores selection, cs and words
  task automatic t_sweep_ignores();
    int n;
    ext_sel_pin = 1'b1;
    @(negedge clk);
    reset_req = 1'b1;
    @(negedge clk);
    reset_req = 1'b0;
    seen = s_cnt;
    check(busy == 1'b1, "R8 busy on reset request", busy, 1);
    cs_n = 1'b0;
    send_word(3, 16'hBEEF, 1'b1, 1'b0);
    cs_n = 1'b1;
    for (int k = 0; k < NCH; k++) begin
      next_strobe("R9 sweep runs on internal tick");
      check(s_ch == k && s_code == DEF, "R9 sweep strobe", s_code, DEF);
      model[k] = DEF;
    end
    @(negedge clk);
    check(busy == 1'b0, "R9 sweep finished", busy, 0);
    ext_sel_pin = 1'b0;
    n = 0;
    do begin
      next_strobe("R9 post sweep strobe");
      n++;
    end while (s_ch != 3 && n < 20);
    check(s_ch == 3 && s_code == DEF, "R9 word during sweep not stored", s_code, DEF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_sweep();
    t_burst();
    t_immediate(12, 16'hA5C3, 1'b0);
    t_immediate(5, 16'h7E11, 1'b1);
    t_external();
    t_sweep_ignores();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule